// File: doc/BRIEF.md
# Machine-Cycle and DMA Sequencer

This block paces a small 8-bit processor core. It splits every machine cycle into a fixed number of input-clock phases, eight by default. It reports the current phase and the kind of cycle as a two-bit state code. It raises an early address pulse and a late end-of-cycle pulse, and it drives the active-low memory read and write strobes at fixed phases inside each cycle. The instruction decoder tells the block, during the fetch cycle, whether the execute cycle that follows reads memory, writes memory or does neither.

Cycle-stealing DMA and interrupt service are added as whole extra machine cycles between an execute cycle and the next fetch. A DMA transfer uses a dedicated pointer register as its memory address, and the pointer steps by one after each transfer. A pause input freezes all timing in place. Releasing pause resumes from the same phase. A DMA data strobe marks the end-of-cycle pulse of DMA cycles so that an output device can capture memory data.

Top module: `mcs_cycle_seq`

## Requirements
- R1: The `phase` output counts 0,1,...,7 and then wraps, so each machine cycle lasts eight clocks. `tpa` is high only in phase 1 and `tpb` is high only in phase 6.
- R2: State codes are fetch 2'b00, execute 2'b01, DMA 2'b10 and interrupt 2'b11. A fetch cycle is always followed by an execute cycle. A fetch cycle reads memory, with `mrd_n` low in phases 1 to 7.
- R3: At the end of an execute or DMA cycle, a pending DMA request (either direction) selects a DMA cycle. If no DMA request is pending, `irq_req` selects an interrupt cycle. Otherwise the next cycle is a fetch. Requests are sampled in phase 7, and an interrupt cycle is always followed by a fetch.
- R4: A DMA-in cycle holds `mwr_n` low in phases 5 and 6 and keeps `mrd_n` high for the whole cycle. When both DMA requests are pending, DMA-in is chosen.
- R5: A DMA-out cycle holds `mrd_n` low in phases 1 to 7. `dma_strobe` equals (state code 2'b10) AND `tpb`, so it is high only in phase 6 of a DMA cycle.
- R6: `dma_addr` shows the DMA pointer. The pointer increments by one, modulo 2^PTR_W, at the end of every DMA cycle and holds its value otherwise.
- R7: While `pause` is high at a clock edge, the phase, the cycle kind, the pointer and every output hold their values. After `pause` is released, counting resumes from the held phase.
- R8: In a non-memory cycle (interrupt, execute of kind none, or the initialisation cycle), `mrd_n` and `mwr_n` both stay high for all eight phases. The two strobes are never low together.
- R9: Synchronous reset sets the phase to 0 and the pointer to 0, and starts an initialisation cycle. That cycle shows state code 2'b01, drives no strobes, clears the pointer and is followed by a fetch.
- R10: `exec_kind` is sampled in phase 7 of a fetch cycle. Its codes are 0 none, 1 read and 2 write, and 3 acts as none. A read-kind execute cycle has `mrd_n` low in phases 1 to 7. A write-kind execute cycle has `mwr_n` low in phases 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| pause | input | 1 | Freezes timing while high |
| dma_in_req | input | 1 | Request to move device data into memory |
| dma_out_req | input | 1 | Request to move memory data to a device |
| irq_req | input | 1 | Interrupt request |
| exec_kind | input | 2 | Memory use of the coming execute cycle |
| phase | output | PH_W | Clock phase within the machine cycle |
| tpa | output | 1 | Early address timing pulse |
| tpb | output | 1 | End-of-cycle timing pulse |
| state_code | output | 2 | Current machine-cycle kind |
| mrd_n | output | 1 | Memory read strobe, active low |
| mwr_n | output | 1 | Memory write strobe, active low |
| dma_strobe | output | 1 | DMA data strobe |
| dma_addr | output | PTR_W | DMA pointer used as the memory address |

## Verification
The bench sweeps every combination of the three request inputs against every code of `exec_kind`. This separates priority errors (interrupt chosen over DMA, or DMA-out chosen over DMA-in) from errors in the strobe windows of each execute kind. It checks every phase of every cycle against windows computed from the phase number, so a pulse or strobe moved by one phase is caught. Directed runs with back-to-back DMA cycles and pauses in phase 3 and phase 7 show whether the pointer steps once per transfer and whether a pause lets anything slip. With a 4-bit pointer the sweep wraps the pointer, and a reset in the middle of a cycle shows that reset clears it.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [2:0] {
        CYC_INIT    = 3'd0,
        CYC_FETCH   = 3'd1,
        CYC_EXEC    = 3'd2,
        CYC_DMA_IN  = 3'd3,
        CYC_DMA_OUT = 3'd4,
        CYC_INT     = 3'd5
    } cyc_e;

    typedef enum logic [1:0] {
        MEM_NONE  = 2'd0,
        MEM_READ  = 2'd1,
        MEM_WRITE = 2'd2,
        MEM_RSVD  = 2'd3
    } mem_e;

    localparam logic [1:0] SC_FETCH = 2'b00;
    localparam logic [1:0] SC_EXEC  = 2'b01;
    localparam logic [1:0] SC_DMA   = 2'b10;
    localparam logic [1:0] SC_INT   = 2'b11;

    typedef struct packed {
        logic tpa;
        logic tpb;
        logic rd_n;
        logic wr_n;
        logic dstb;
    } strobe_t;

    // two-bit state code presented for each cycle kind
    function automatic logic [1:0] state_code_of(cyc_e c);
        case (c)
            CYC_FETCH:   return SC_FETCH;
            CYC_DMA_IN:  return SC_DMA;
            CYC_DMA_OUT: return SC_DMA;
            CYC_INT:     return SC_INT;
            default:     return SC_EXEC;
        endcase
    endfunction

    // memory use of a cycle; the reserved execute code acts as none
    function automatic mem_e mem_use_of(cyc_e c, mem_e ek);
        case (c)
            CYC_FETCH:   return MEM_READ;
            CYC_DMA_OUT: return MEM_READ;
            CYC_DMA_IN:  return MEM_WRITE;
            CYC_EXEC:    return (ek == MEM_RSVD) ? MEM_NONE : ek;
            default:     return MEM_NONE;
        endcase
    endfunction

    // cycle that follows an execute or DMA cycle
    function automatic cyc_e after_exec(logic din, logic dout, logic irq);
        if (din)       return CYC_DMA_IN;
        else if (dout) return CYC_DMA_OUT;
        else if (irq)  return CYC_INT;
        else           return CYC_FETCH;
    endfunction

endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
    parameter int PHASES = 8,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pause,
    output logic [PH_W-1:0] phase,
    output logic            cyc_end
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else if (!pause) begin
            if (ph_q == LAST) ph_q <= '0;
            else              ph_q <= ph_q + 1'b1;
        end
    end

    assign phase   = ph_q;
    assign cyc_end = (ph_q == LAST) && !pause;
endmodule

// File: rtl/mcs_state_seq.sv
module mcs_state_seq
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_end,
    input  logic       dma_in_req,
    input  logic       dma_out_req,
    input  logic       irq_req,
    input  logic [1:0] exec_kind,
    output cyc_e       cur_cyc,
    output mem_e       exec_mem
);
    cyc_e cyc_q, cyc_d;
    mem_e ek_q;

    always_comb begin
        case (cyc_q)
            CYC_INIT:    cyc_d = CYC_FETCH;
            CYC_FETCH:   cyc_d = CYC_EXEC;
            CYC_EXEC:    cyc_d = after_exec(dma_in_req, dma_out_req, irq_req);
            CYC_DMA_IN:  cyc_d = after_exec(dma_in_req, dma_out_req, irq_req);
            CYC_DMA_OUT: cyc_d = after_exec(dma_in_req, dma_out_req, irq_req);
            CYC_INT:     cyc_d = CYC_FETCH;
            default:     cyc_d = CYC_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CYC_INIT;
            ek_q  <= MEM_NONE;
        end else if (cyc_end) begin
            cyc_q <= cyc_d;
            if (cyc_q == CYC_FETCH) ek_q <= mem_e'(exec_kind);
        end
    end

    assign cur_cyc  = cyc_q;
    assign exec_mem = ek_q;
endmodule

// File: rtl/mcs_strobe_gen.sv
module mcs_strobe_gen
    import mcs_pkg::*;
#(
    parameter int PH_W     = 3,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int RD_FIRST = 1,
    parameter int RD_LAST  = 7,
    parameter int WR_FIRST = 5,
    parameter int WR_LAST  = 6
) (
    input  logic [PH_W-1:0] phase,
    input  cyc_e            cur_cyc,
    input  mem_e            exec_mem,
    output logic [1:0]      state_code,
    output strobe_t         strb
);
    logic [31:0] ph32;
    logic        in_rd_win, in_wr_win;
    mem_e        use_q;

    assign ph32      = 32'(phase);
    assign in_rd_win = (ph32 >= 32'(RD_FIRST)) && (ph32 <= 32'(RD_LAST));
    assign in_wr_win = (ph32 >= 32'(WR_FIRST)) && (ph32 <= 32'(WR_LAST));
    assign use_q     = mem_use_of(cur_cyc, exec_mem);

    always_comb begin
        state_code = state_code_of(cur_cyc);
        strb.tpa   = (ph32 == 32'(TPA_PH));
        strb.tpb   = (ph32 == 32'(TPB_PH));
        strb.rd_n  = !((use_q == MEM_READ) && in_rd_win);
        strb.wr_n  = !((use_q == MEM_WRITE) && in_wr_win);
        strb.dstb  = (state_code == SC_DMA) && strb.tpb;
    end
endmodule

// File: rtl/mcs_dma_ptr.sv
module mcs_dma_ptr
    import mcs_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_end,
    input  cyc_e             cur_cyc,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_q;
    logic             is_dma;

    assign is_dma = (cur_cyc == CYC_DMA_IN) || (cur_cyc == CYC_DMA_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (cyc_end) begin
            if (cur_cyc == CYC_INIT) ptr_q <= '0;
            else if (is_dma)         ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/mcs_cycle_seq.sv
module mcs_cycle_seq
    import mcs_pkg::*;
#(
    parameter int PHASES = 8,
    parameter int PTR_W  = 16,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pause,
    input  logic             dma_in_req,
    input  logic             dma_out_req,
    input  logic             irq_req,
    input  logic [1:0]       exec_kind,
    output logic [PH_W-1:0]  phase,
    output logic             tpa,
    output logic             tpb,
    output logic [1:0]       state_code,
    output logic             mrd_n,
    output logic             mwr_n,
    output logic             dma_strobe,
    output logic [PTR_W-1:0] dma_addr
);
    logic    cyc_end;
    cyc_e    cur_cyc;
    mem_e    exec_mem;
    strobe_t strb;

    mcs_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .pause   (pause),
        .phase   (phase),
        .cyc_end (cyc_end)
    );

    mcs_state_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cyc_end     (cyc_end),
        .dma_in_req  (dma_in_req),
        .dma_out_req (dma_out_req),
        .irq_req     (irq_req),
        .exec_kind   (exec_kind),
        .cur_cyc     (cur_cyc),
        .exec_mem    (exec_mem)
    );

    mcs_strobe_gen #(
        .PH_W     (PH_W),
        .TPA_PH   (1),
        .TPB_PH   (PHASES - 2),
        .RD_FIRST (1),
        .RD_LAST  (PHASES - 1),
        .WR_FIRST (PHASES - 3),
        .WR_LAST  (PHASES - 2)
    ) u_strb (
        .phase      (phase),
        .cur_cyc    (cur_cyc),
        .exec_mem   (exec_mem),
        .state_code (state_code),
        .strb       (strb)
    );

    mcs_dma_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .cyc_end (cyc_end),
        .cur_cyc (cur_cyc),
        .ptr     (dma_addr)
    );

    assign tpa        = strb.tpa;
    assign tpb        = strb.tpb;
    assign mrd_n      = strb.rd_n;
    assign mwr_n      = strb.wr_n;
    assign dma_strobe = strb.dstb;
endmodule

// File: rtl/mcs_cycle_seq_chk.sv
module mcs_cycle_seq_chk
    import mcs_pkg::*;
#(
    parameter int PHASES = 8,
    parameter int PTR_W  = 16,
    localparam int PH_W  = $clog2(PHASES)
) (
    input logic             clk,
    input logic             rst,
    input logic             pause,
    input logic             dma_in_req,
    input logic             dma_out_req,
    input logic             irq_req,
    input logic [PH_W-1:0]  phase,
    input logic             tpa,
    input logic             tpb,
    input logic [1:0]       state_code,
    input logic             mrd_n,
    input logic             mwr_n,
    input logic             dma_strobe,
    input logic [PTR_W-1:0] dma_addr,
    input cyc_e             cur_cyc
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    assert_phase_adv_R1: assert property (@(posedge clk) disable iff (rst)
        !pause |=> phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1));

    assert_pulse_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(tpa && tpb));

    assert_fetch_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_cyc == CYC_FETCH && phase == LAST && !pause) |=> state_code == 2'b01);

    assert_dma_first_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_cyc == CYC_EXEC && phase == LAST && !pause && (dma_in_req || dma_out_req))
        |=> state_code == 2'b10);

    assert_irq_only_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_cyc == CYC_EXEC && phase == LAST && !pause && !dma_in_req && !dma_out_req && irq_req)
        |=> state_code == 2'b11);

    assert_din_rd_high_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_cyc == CYC_DMA_IN) |-> mrd_n);

    assert_dstb_R5: assert property (@(posedge clk) disable iff (rst)
        dma_strobe |-> (state_code == 2'b10 && tpb));

    assert_ptr_inc_R6: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b10 && phase == LAST && !pause) |=> dma_addr == $past(dma_addr) + 1'b1);

    assert_pause_hold_R7: assert property (@(posedge clk) disable iff (rst)
        pause |=> ($stable(phase) && $stable(state_code) && $stable(dma_addr)));

    assert_no_dual_R8: assert property (@(posedge clk) disable iff (rst)
        !(!mrd_n && !mwr_n));
endmodule

bind mcs_cycle_seq mcs_cycle_seq_chk #(.PHASES(PHASES), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pause       (pause),
    .dma_in_req  (dma_in_req),
    .dma_out_req (dma_out_req),
    .irq_req     (irq_req),
    .phase       (phase),
    .tpa         (tpa),
    .tpb         (tpb),
    .state_code  (state_code),
    .mrd_n       (mrd_n),
    .mwr_n       (mwr_n),
    .dma_strobe  (dma_strobe),
    .dma_addr    (dma_addr),
    .cur_cyc     (cur_cyc)
);

// File: tb/test_mcs_cycle_seq.sv
`timescale 1ns/1ps
module test_mcs_cycle_seq;
    localparam int PTR_W = 4;
    localparam int K_INIT = 0, K_FETCH = 1, K_EXN = 2, K_EXR = 3, K_EXW = 4,
                   K_DIN = 5, K_DOUT = 6, K_INT = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pause = 1'b0;
    logic             dma_in_req = 1'b0, dma_out_req = 1'b0, irq_req = 1'b0;
    logic [1:0]       exec_kind = 2'd0;
    logic [2:0]       phase;
    logic             tpa, tpb, mrd_n, mwr_n, dma_strobe;
    logic [1:0]       state_code;
    logic [PTR_W-1:0] dma_addr;

    int n_chk = 0, n_fail = 0, exp_ptr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mcs_cycle_seq #(.PHASES(8), .PTR_W(PTR_W)) i_mcs_cycle_seq (
        .clk(clk), .rst(rst), .pause(pause),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .irq_req(irq_req),
        .exec_kind(exec_kind), .phase(phase), .tpa(tpa), .tpb(tpb),
        .state_code(state_code), .mrd_n(mrd_n), .mwr_n(mwr_n),
        .dma_strobe(dma_strobe), .dma_addr(dma_addr)
    );

    // expected vector: phase, tpa, tpb, code, mrd_n, mwr_n, strobe, pointer
    task automatic check_phase(int k, int p, string tag);
        logic [1:0]  code;
        logic        rd, wr;
        logic [15:0] exp_v, got_v;
        case (k)
            K_FETCH:       code = 2'b00;
            K_DIN, K_DOUT: code = 2'b10;
            K_INT:         code = 2'b11;
            default:       code = 2'b01;
        endcase
        rd = (k == K_FETCH || k == K_EXR || k == K_DOUT) && p >= 1 && p <= 7;
        wr = (k == K_EXW || k == K_DIN) && p >= 5 && p <= 6;
        exp_v = {3'(p), p == 1, p == 6, code, !rd, !wr, code == 2'b10 && p == 6, 4'(exp_ptr)};
        got_v = {phase, tpa, tpb, state_code, mrd_n, mwr_n, dma_strobe, dma_addr};
        n_chk++;
        if (got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s/R1 kind %0d phase %0d: got %b expected %b", tag, k, p, got_v, exp_v);
        end
    endtask

    task automatic run_cycle(int k, string tag, int pause_at = -1, int hold = 0);
        for (int p = 0; p < 8; p++) begin
            check_phase(k, p, tag);
            if (p == pause_at) begin
                pause = 1'b1;
                repeat (hold) begin
                    @(negedge clk);
                    check_phase(k, p, "R7");
                end
                pause = 1'b0;
            end
            @(negedge clk);
        end
        if (k == K_DIN || k == K_DOUT) exp_ptr = (exp_ptr + 1) % (1 << PTR_W);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_cycle(K_INIT, "R9");                  // R9 reset state, init cycle

        exec_kind = 2'd1;
        run_cycle(K_FETCH, "R2");
        run_cycle(K_EXR, "R10");

        exec_kind = 2'd2;
        run_cycle(K_FETCH, "R2");
        dma_out_req = 1'b1;
        run_cycle(K_EXW, "R10");
        run_cycle(K_DOUT, "R5");                  // back-to-back DMA, R6 pointer step
        dma_out_req = 1'b0; dma_in_req = 1'b1;
        run_cycle(K_DOUT, "R5", 3, 4);            // pause mid-cycle, R7
        dma_out_req = 1'b1;                        // both pending: R4 priority
        run_cycle(K_DIN, "R4");
        dma_in_req = 1'b0; dma_out_req = 1'b0; irq_req = 1'b1;
        run_cycle(K_DIN, "R4", 7, 3);             // pause at last phase: R6 pointer held
        run_cycle(K_INT, "R8");                   // irq still high, next is fetch (R3)
        irq_req = 1'b0;

        // R3 sweep over exec codes and request combinations
        for (int ek = 0; ek < 4; ek++) begin
            for (int r = 0; r < 8; r++) begin
                int ek_k, nk;
                exec_kind = 2'(ek);
                run_cycle(K_FETCH, "R2");
                dma_in_req = r[0]; dma_out_req = r[1]; irq_req = r[2];
                ek_k = (ek == 1) ? K_EXR : (ek == 2) ? K_EXW : K_EXN;
                run_cycle(ek_k, (ek_k == K_EXN) ? "R8" : "R10");
                nk = r[0] ? K_DIN : r[1] ? K_DOUT : r[2] ? K_INT : K_FETCH;
                dma_in_req = 1'b0; dma_out_req = 1'b0; irq_req = 1'b0;
                if (nk != K_FETCH) run_cycle(nk, "R3");
            end
        end

        // R9 reset in the middle of a cycle clears the pointer (R6 wrap already passed)
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_ptr = 0;
        run_cycle(K_INIT, "R9");
        run_cycle(K_FETCH, "R9");

        done = 1;
        report();
        $finish;
    end
endmodule